// File: doc/BRIEF.md
# Ring-Oscillator Race Measurement Controller

This block measures a bank of ring oscillators used as a physically unclonable function. A pair index chooses two oscillators out of the bank. Each oscillator of the pair feeds its own counter, and the two counters race. The first counter to wrap past its all-ones value ends the race. At that moment the block freezes the count held by the other counter and reports it as the measurement. A programmable mask then picks bits out of that value to form the response.

Software-side control logic drives the block. It sets the pair index, the number of repetitions and the response mask, then pulses a start input. Each repetition produces one result together with a one-cycle valid strobe, so a downstream serializer can ship the result straight away. The counters restart from zero for every repetition. Busy and done levels show the progress of a run. In simulation the oscillators are plain toggling inputs. Each input passes through a two-flop synchronizer and a rising-edge detector before it is counted.

Top module: `ropuf_race_ctrl`

## Requirements
- R1: After reset, busy, done and result_valid are low.
- R2: A start pulse while not busy, with a nonzero repetition count, raises busy and clears done on the next cycle. At that edge the block latches the pair index, the mask and the count. Pair p uses oscillator 2p as racer A and oscillator 2p+1 as racer B.
- R3: Each counter is CNT_W bits wide (16 by default). It counts rising edges of its racer once they have passed through the synchronizer. Both counters return to zero at start and after every capture. Edges on oscillators outside the latched pair have no effect.
- R4: When counter A is all ones and sees a new edge while B does not wrap, result carries B's count from before that cycle. result_tie is 0 and result_valid is high for exactly one cycle.
- R5: When counter B wraps alone, result carries A's count from before that cycle and result_tie is 0.
- R6: When both counters wrap in the same cycle, result is B's value (all ones) and result_tie is 1.
- R7: resp_bits holds the result bits whose mask bit is 1, packed toward bit 0 in ascending bit order. All bits above the packed ones are zero.
- R8: After the programmed number of captures, busy falls and done rises in the same cycle as the last result_valid. Done stays high until the next accepted start.
- R9: A start with a repetition count of zero makes no measurement. done is high and busy is low on the next cycle.
- R10: A start pulse, or a change of pair_sel, resp_mask or rep_count, has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_i | input | 2*N_PAIRS | Ring-oscillator outputs, asynchronous |
| pair_sel | input | $clog2(N_PAIRS) | Oscillator pair index |
| rep_count | input | REP_W | Number of measurements in a run |
| resp_mask | input | CNT_W | Response bit selection mask |
| start | input | 1 | Run start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| result | output | CNT_W | Captured count of the losing counter |
| result_valid | output | 1 | One-cycle strobe for result and resp_bits |
| result_tie | output | 1 | Both counters wrapped together |
| resp_bits | output | CNT_W | Masked response bits packed toward bit 0 |

## Verification
The race is driven with three edge-rate patterns. In the first, A is faster than B, so the captured value must come from counter B. In the second, B is faster, which distinguishes a correct capture source from a swapped one. In the third, both racers run at the same rate from zero, which exposes the tie rule and its flag. During one multi-repetition run the bench changes the pair index and pulses start again while the unselected oscillators keep toggling. Any leakage from the wrong pair or any accepted restart would shift the captured counts. Sparse and dense masks tell correct packing apart from a plain bitwise AND. A zero repetition count checks that a run can finish without any measurement.

// File: rtl/ropuf_pkg.sv
package ropuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } race_state_e;
endpackage

// File: rtl/ropuf_rst_sync.sv
module ropuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/ropuf_edge_sync.sv
module ropuf_edge_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] osc_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= osc_i[g];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign rise_o[g] = sync_q & ~last_q;

    // R3
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/ropuf_race_pair.sv
module ropuf_race_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         tick_a,
  input  logic         tick_b,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic         wrap_a,
  output logic         wrap_b
);
  logic [W-1:0] cnt_a_q, cnt_a_d;
  logic [W-1:0] cnt_b_q, cnt_b_d;

  always_comb begin
    cnt_a_d = cnt_a_q;
    cnt_b_d = cnt_b_q;
    if (clr) begin
      cnt_a_d = '0;
      cnt_b_d = '0;
    end else if (en) begin
      if (tick_a) cnt_a_d = cnt_a_q + 1'b1;
      if (tick_b) cnt_b_d = cnt_b_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a_q <= '0;
      cnt_b_q <= '0;
    end else begin
      cnt_a_q <= cnt_a_d;
      cnt_b_q <= cnt_b_d;
    end
  end

  assign wrap_a = en & tick_a & (&cnt_a_q);
  assign wrap_b = en & tick_b & (&cnt_b_q);
  assign cnt_a  = cnt_a_q;
  assign cnt_b  = cnt_b_q;

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_a_q == '0) && (cnt_b_q == '0));

  // R3
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(en && tick_a)) |=> $stable(cnt_a_q));

  // R3
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(en && tick_b)) |=> $stable(cnt_b_q));
endmodule

// File: rtl/ropuf_bit_pack.sv
module ropuf_bit_pack #(
  parameter int W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] packed_o
);
  localparam int IDX_W = $clog2(W);

  always_comb begin
    logic [IDX_W:0] pos;
    packed_o = '0;
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (mask_i[i]) begin
        packed_o[pos[IDX_W-1:0]] = data_i[i];
        pos = pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ropuf_ctrl.sv
module ropuf_ctrl
  import ropuf_pkg::*;
#(
  parameter int W      = 16,
  parameter int REP_W  = 8,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REP_W-1:0]  rep_count,
  input  logic [PSEL_W-1:0] pair_sel,
  input  logic [W-1:0]      resp_mask,
  input  logic [W-1:0]      cnt_a,
  input  logic [W-1:0]      cnt_b,
  input  logic              wrap_a,
  input  logic              wrap_b,
  input  logic [W-1:0]      resp_packed,
  output logic [W-1:0]      capt_o,
  output logic [W-1:0]      mask_o,
  output logic [PSEL_W-1:0] pair_o,
  output logic              clr_o,
  output logic              en_o,
  output logic              busy,
  output logic              done,
  output logic [W-1:0]      result,
  output logic              result_valid,
  output logic              result_tie,
  output logic [W-1:0]      resp_bits
);
  race_state_e       state_q, state_d;
  logic [REP_W-1:0]  left_q, left_d;
  logic [PSEL_W-1:0] pair_q, pair_d;
  logic [W-1:0]      mask_q, mask_d;
  logic [W-1:0]      res_q, res_d;
  logic [W-1:0]      resp_q, resp_d;
  logic              tie_q, tie_d;
  logic              vld_q, vld_d;
  logic              any_wrap;

  assign any_wrap = wrap_a | wrap_b;
  // A tie or a lone A wrap takes B's count; a lone B wrap takes A's.
  assign capt_o   = (wrap_a | ~wrap_b) ? cnt_b : cnt_a;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    pair_d  = pair_q;
    mask_d  = mask_q;
    res_d   = res_q;
    resp_d  = resp_q;
    tie_d   = tie_q;
    vld_d   = 1'b0;
    clr_o   = 1'b0;
    en_o    = (state_q == ST_RUN);
    unique case (state_q)
      ST_RUN: begin
        if (any_wrap) begin
          res_d  = capt_o;
          resp_d = resp_packed;
          tie_d  = wrap_a & wrap_b;
          vld_d  = 1'b1;
          clr_o  = 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == REP_W'(1)) state_d = ST_DONE;
        end
      end
      default: begin
        if (start) begin
          pair_d = pair_sel;
          mask_d = resp_mask;
          left_d = rep_count;
          clr_o  = 1'b1;
          state_d = (rep_count == '0) ? ST_DONE : ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      pair_q  <= '0;
      mask_q  <= '0;
      res_q   <= '0;
      resp_q  <= '0;
      tie_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      pair_q  <= pair_d;
      mask_q  <= mask_d;
      res_q   <= res_d;
      resp_q  <= resp_d;
      tie_q   <= tie_d;
      vld_q   <= vld_d;
    end
  end

  assign busy         = (state_q == ST_RUN);
  assign done         = (state_q == ST_DONE);
  assign result       = res_q;
  assign result_valid = vld_q;
  assign result_tie   = tie_q;
  assign resp_bits    = resp_q;
  assign mask_o       = mask_q;
  assign pair_o       = pair_q;

  // R4
  valid_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(busy));

  // R6
  tie_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result_tie) |-> (result == '1));

  // R10
  busy_pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pair_q) && $stable(mask_q));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(busy)) |-> result_valid);
endmodule

// File: rtl/ropuf_race_ctrl.sv
module ropuf_race_ctrl #(
  parameter int N_PAIRS = 4,
  parameter int CNT_W   = 16,
  parameter int REP_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*N_PAIRS-1:0]       osc_i,
  input  logic [$clog2(N_PAIRS)-1:0] pair_sel,
  input  logic [REP_W-1:0]           rep_count,
  input  logic [CNT_W-1:0]           resp_mask,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  output logic [CNT_W-1:0]           result,
  output logic                       result_valid,
  output logic                       result_tie,
  output logic [CNT_W-1:0]           resp_bits
);
  localparam int PSEL_W = $clog2(N_PAIRS);
  localparam int N_OSC  = 2 * N_PAIRS;

  logic              rst_int_n;
  logic [N_OSC-1:0]  rise;
  logic [PSEL_W-1:0] pair_q;
  logic              tick_a, tick_b;
  logic              clr, en;
  logic [CNT_W-1:0]  cnt_a, cnt_b;
  logic              wrap_a, wrap_b;
  logic [CNT_W-1:0]  capt, mask_q, packed_bits;

  ropuf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ropuf_edge_sync #(.N(N_OSC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .osc_i  (osc_i),
    .rise_o (rise)
  );

  assign tick_a = rise[{pair_q, 1'b0}];
  assign tick_b = rise[{pair_q, 1'b1}];

  ropuf_race_pair #(.W(CNT_W)) u_pair (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (clr),
    .en     (en),
    .tick_a (tick_a),
    .tick_b (tick_b),
    .cnt_a  (cnt_a),
    .cnt_b  (cnt_b),
    .wrap_a (wrap_a),
    .wrap_b (wrap_b)
  );

  ropuf_bit_pack #(.W(CNT_W)) u_pack (
    .data_i   (capt),
    .mask_i   (mask_q),
    .packed_o (packed_bits)
  );

  ropuf_ctrl #(.W(CNT_W), .REP_W(REP_W), .PSEL_W(PSEL_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start        (start),
    .rep_count    (rep_count),
    .pair_sel     (pair_sel),
    .resp_mask    (resp_mask),
    .cnt_a        (cnt_a),
    .cnt_b        (cnt_b),
    .wrap_a       (wrap_a),
    .wrap_b       (wrap_b),
    .resp_packed  (packed_bits),
    .capt_o       (capt),
    .mask_o       (mask_q),
    .pair_o       (pair_q),
    .clr_o        (clr),
    .en_o         (en),
    .busy         (busy),
    .done         (done),
    .result       (result),
    .result_valid (result_valid),
    .result_tie   (result_tie),
    .resp_bits    (resp_bits)
  );

  // R7
  resp_width_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    result_valid |-> ($countones(resp_bits) <= $countones(result)));
endmodule

// File: tb/tb_ropuf_race_ctrl.sv
module tb_ropuf_race_ctrl;
  localparam int NP   = 4;
  localparam int W    = 8;
  localparam int RW   = 4;
  localparam int MAXV = (1 << W) - 1;

  logic          clk;
  logic          rst_n;
  logic [2*NP-1:0] osc_i;
  logic [1:0]    pair_sel;
  logic [RW-1:0] rep_count;
  logic [W-1:0]  resp_mask;
  logic          start;
  logic          busy, done, result_valid, result_tie;
  logic [W-1:0]  result, resp_bits;

  int checks = 0;
  int errors = 0;
  logic [2*W:0] exp_q[$];

  ropuf_race_ctrl #(.N_PAIRS(NP), .CNT_W(W), .REP_W(RW)) dut (
    .clk (clk), .rst_n (rst_n), .osc_i (osc_i), .pair_sel (pair_sel),
    .rep_count (rep_count), .resp_mask (resp_mask), .start (start),
    .busy (busy), .done (done), .result (result),
    .result_valid (result_valid), .result_tie (result_tie),
    .resp_bits (resp_bits)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pack_ref(input logic [W-1:0] v,
                                            input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int j = 0;
    for (int i = 0; i < W; i++)
      if (m[i]) begin r[j] = v[i]; j++; end
    return r;
  endfunction

  // Monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected result_valid", result, 0);
      end else begin
        logic [2*W:0] e;
        e = exp_q.pop_front();
        chk(result == e[2*W:W+1], e[W] ? "R6" : "R4/R5", "result",
            result, e[2*W:W+1]);
        chk(result_tie == e[W], "R6", "tie flag", result_tie, e[W]);
        chk(resp_bits == e[W-1:0], "R7", "resp_bits", resp_bits, e[W-1:0]);
      end
    end
  end

  // Driver: one run, oscillator A edge every pa steps, B every pb steps
  task automatic run_case(input int pair, input int reps, input logic [W-1:0] mask,
                          input int pa, input int oa, input int pb, input int ob,
                          input bit disturb);
    int ca = 0, cb = 0, got = 0, s = 0;
    @(negedge clk);
    pair_sel = 2'(pair); rep_count = RW'(reps); resp_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R2", "busy after start", {busy, done}, 2'b10);
    @(negedge clk);
    while (got < reps) begin
      bit a, b, wa, wb;
      logic [W-1:0] v;
      a = ((s + oa) % pa) == 0;
      b = ((s + ob) % pb) == 0;
      wa = a && (ca == MAXV);
      wb = b && (cb == MAXV);
      if (wa || wb) begin
        v = (wa) ? W'(cb) : W'(ca);
        exp_q.push_back({v, wa && wb, pack_ref(v, mask)});
        ca = 0; cb = 0; got++;
      end else begin
        ca += int'(a); cb += int'(b);
      end
      osc_i = '1;
      osc_i[2*pair]   = a;
      osc_i[2*pair+1] = b;
      // R10: restart attempt and input changes while busy
      if (disturb && s == 100) begin
        start = 1'b1; pair_sel = 2'((pair + 1) % NP);
        resp_mask = ~mask; rep_count = '0;
      end
      @(negedge clk);
      osc_i = '0;
      start = 1'b0;
      @(negedge clk);
      s++;
    end
    repeat (6) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R8", "done after run", {busy, done}, 2'b01);
    chk(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    osc_i = '0; pair_sel = '0; rep_count = '0; resp_mask = '0; start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && result_valid == 0, "R1", "reset state",
        {busy, done, result_valid}, 0);

    // R9: zero repetitions
    pair_sel = 2'd1; rep_count = '0; resp_mask = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R9", "zero-count run", {busy, done}, 2'b01);
    for (int k = 0; k < 20; k++) begin
      osc_i = '1; @(negedge clk); osc_i = '0; @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b0, "R9", "zero-count stays done", {busy, done}, 2'b01);

    // R4: A faster, B captured
    run_case(1, 2, 8'hFF, 1, 0, 3, 1, 1'b0);
    // R5: B faster, A captured
    run_case(2, 1, 8'h0F, 2, 1, 1, 0, 1'b0);
    // R6: equal rates give a tie
    run_case(0, 1, 8'hA5, 1, 0, 1, 0, 1'b0);
    // R3 and R10: other pairs toggle, restart and input changes mid-run ignored
    run_case(3, 3, 8'h3C, 1, 0, 2, 1, 1'b1);

    report();
  end
endmodule